// File: doc/BRIEF.md
# Context-Rooted Three-Level Page Table Walker

This block turns a translation miss into a memory walk. A miss request carries a process context number and a 20-bit virtual page number. The walker first reads the context table, which is indexed by the context number. That read gives the base of a first-level table. The walker then descends through three table levels. Each level costs one memory read, and the index for that read is a field of the virtual page number.

A valid third-level entry is a leaf. It goes out on the fill port, where the translation buffer installs it. If any entry on the path has its valid bit clear, the walker raises a fault pulse that reports which level failed, and it makes no fill. Memory reads use a valid/ready request channel. A separate response strobe returns the data. Only one read is in flight at a time.

Top module: `tbl_walker`

## Requirements
- R1: After reset the walker is idle. `missReady` is 1, and `memReqValid`, `fillValid` and `faultValid` are 0.
- R2: `missReady` is 1 only while idle. A miss is taken on an edge where `missValid` and `missReady` are both 1. A miss presented while a walk is in progress is ignored, and the walk in progress keeps its own context and page number.
- R3: The first read of a walk goes to `CTX_BASE + ctx*4`.
- R4: Every table entry uses bit 0 as its valid bit. A valid non-leaf entry gives the next table base, which is the entry with bits 1:0 cleared. The reads for levels 1, 2 and 3 go to that base plus 4 times the index. The indices are VPN[19:12], VPN[11:6] and VPN[5:0].
- R5: A read request stays asserted with a stable address until `memReqReady` is 1. After the handshake, `memReqValid` stays 0 until `memRspValid` returns the data.
- R6: A valid level-3 entry is delivered in the cycle after its response. `fillValid` is high for exactly one cycle. `fillPte` carries the entry unchanged: bit 0 valid, bit 1 read, bit 2 write, bit 3 execute, bit 4 dirty, bit 5 referenced, bits 31:12 physical page. `reqCtx` and `reqVpn` hold the values from the request.
- R7: An invalid entry at any level raises `faultValid` for exactly one cycle, in the cycle after that response. `faultLevel` is 0 for the context table and 1 to 3 for the table levels. No further reads and no fill follow.
- R8: The walker is idle again in the cycle after a fill or a fault.
- R9: `fillValid` and `faultValid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| missValid | input | 1 | Miss request present |
| missReady | output | 1 | Walker idle and able to take a miss |
| missCtx | input | CTX_W | Context number of the miss |
| missVpn | input | VPN_W | Virtual page number of the miss |
| memReqValid | output | 1 | Memory read request |
| memReqReady | input | 1 | Memory accepts the request |
| memReqAddr | output | ADDR_W | Byte address of the read |
| memRspValid | input | 1 | Read data returned |
| memRspData | input | ADDR_W | Table entry read |
| fillValid | output | 1 | Leaf delivered to the translation buffer |
| fillPte | output | ADDR_W | Leaf entry |
| faultValid | output | 1 | Walk ended in a page fault |
| faultLevel | output | 2 | Level of the invalid entry (0 = context) |
| reqCtx | output | CTX_W | Context of the finished walk |
| reqVpn | output | VPN_W | Page number of the finished walk |

## Verification
The first read request appears in the cycle after the miss is taken. After a request handshake, `memReqValid` is low in the next cycle. Each response moves the walk on by one level at the next edge, so the next request, or the fill or fault pulse, appears in the cycle after the response. Idle follows one cycle after that pulse. The bench contains a reference walk that computes every address and the final outcome from the same table contents. Its driver steps on falling edges and checks the ready, fill and fault outputs against the expected phase in every one of those cycles. Runs vary the memory stalls and latencies and the level at which the walk ends.

// File: rtl/walk_pkg.sv
package walk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CTX, ST_L1, ST_L2, ST_L3, ST_FILL, ST_FAULT
  } walk_state_e;

  typedef struct packed {
    logic       capture;
    logic       latchRsp;
    logic [1:0] lvl;
  } walk_strobe_t;
endpackage

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         missValid,
  input  logic         memReqReady,
  input  logic         memRspValid,
  input  logic         rspOk,
  output walk_strobe_t strobe,
  output logic         missReady,
  output logic         memReqValid,
  output logic         fillValid,
  output logic         faultValid,
  output logic [1:0]   faultLevel
);
  walk_state_e state;
  logic        sent;
  logic        walking;
  logic [1:0]  lvl;
  walk_state_e nextLvl;

  always_comb begin
    walking = 1'b1;
    lvl     = 2'd0;
    nextLvl = ST_FILL;
    case (state)
      ST_CTX: begin lvl = 2'd0; nextLvl = ST_L1;   end
      ST_L1:  begin lvl = 2'd1; nextLvl = ST_L2;   end
      ST_L2:  begin lvl = 2'd2; nextLvl = ST_L3;   end
      ST_L3:  begin lvl = 2'd3; nextLvl = ST_FILL; end
      default: walking = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      sent       <= 1'b0;
      faultLevel <= 2'd0;
    end else begin
      case (state)
        ST_IDLE: if (missValid) state <= ST_CTX;
        ST_FILL, ST_FAULT: state <= ST_IDLE;
        default: begin
          if (!sent && memReqReady) sent <= 1'b1;
          if (sent && memRspValid) begin
            sent <= 1'b0;
            if (rspOk) state <= nextLvl;
            else begin
              state      <= ST_FAULT;
              faultLevel <= lvl;
            end
          end
        end
      endcase
    end
  end

  assign missReady       = (state == ST_IDLE);
  assign memReqValid     = walking && !sent;
  assign fillValid       = (state == ST_FILL);
  assign faultValid      = (state == ST_FAULT);
  assign strobe.capture  = missReady && missValid;
  assign strobe.latchRsp = walking && sent && memRspValid;
  assign strobe.lvl      = lvl;
endmodule

// File: rtl/walk_dpath.sv
module walk_dpath
  import walk_pkg::*;
#(
  parameter int CTX_W       = 8,
  parameter int L1_W        = 8,
  parameter int L2_W        = 6,
  parameter int L3_W        = 6,
  parameter int ADDR_W      = 32,
  parameter int ENTRY_BYTES = 4,
  parameter logic [ADDR_W-1:0] CTX_BASE = 'h1000,
  localparam int VPN_W      = L1_W + L2_W + L3_W
)(
  input  logic              clk,
  input  logic              rst,
  input  walk_strobe_t      strobe,
  input  logic [CTX_W-1:0]  missCtx,
  input  logic [VPN_W-1:0]  missVpn,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              rspOk,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] entry,
  output logic [CTX_W-1:0]  ctxQ,
  output logic [VPN_W-1:0]  vpnQ
);
  localparam int OFF_W  = $clog2(ENTRY_BYTES);
  localparam int L1_LSB = L2_W + L3_W;
  localparam int L2_LSB = L3_W;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] idxOff [4];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctxQ  <= '0;
      vpnQ  <= '0;
      entry <= '0;
    end else begin
      if (strobe.capture) begin
        ctxQ <= missCtx;
        vpnQ <= missVpn;
      end
      if (strobe.latchRsp) entry <= memRspData;
    end
  end

  assign idxOff[0] = ADDR_W'(ctxQ) << OFF_W;
  assign idxOff[1] = ADDR_W'(vpnQ[VPN_W-1:L1_LSB]) << OFF_W;
  assign idxOff[2] = ADDR_W'(vpnQ[L1_LSB-1:L2_LSB]) << OFF_W;
  assign idxOff[3] = ADDR_W'(vpnQ[L2_LSB-1:0]) << OFF_W;

  assign base       = (strobe.lvl == 2'd0) ? CTX_BASE
                    : {entry[ADDR_W-1:OFF_W], OFF_W'(0)};
  assign memReqAddr = base + idxOff[strobe.lvl];
  assign rspOk      = memRspData[0];
endmodule

// File: rtl/tbl_walker.sv
module tbl_walker
  import walk_pkg::*;
#(
  parameter int CTX_W       = 8,
  parameter int L1_W        = 8,
  parameter int L2_W        = 6,
  parameter int L3_W        = 6,
  parameter int ADDR_W      = 32,
  parameter int ENTRY_BYTES = 4,
  parameter logic [ADDR_W-1:0] CTX_BASE = 'h1000,
  localparam int VPN_W      = L1_W + L2_W + L3_W
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              missValid,
  output logic              missReady,
  input  logic [CTX_W-1:0]  missCtx,
  input  logic [VPN_W-1:0]  missVpn,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              fillValid,
  output logic [ADDR_W-1:0] fillPte,
  output logic              faultValid,
  output logic [1:0]        faultLevel,
  output logic [CTX_W-1:0]  reqCtx,
  output logic [VPN_W-1:0]  reqVpn
);
  walk_strobe_t strobe;
  logic         rspOk;

  walk_ctrl u_ctrl (
    .clk(clk), .rst(rst), .missValid(missValid), .memReqReady(memReqReady),
    .memRspValid(memRspValid), .rspOk(rspOk), .strobe(strobe),
    .missReady(missReady), .memReqValid(memReqValid), .fillValid(fillValid),
    .faultValid(faultValid), .faultLevel(faultLevel)
  );

  walk_dpath #(
    .CTX_W(CTX_W), .L1_W(L1_W), .L2_W(L2_W), .L3_W(L3_W),
    .ADDR_W(ADDR_W), .ENTRY_BYTES(ENTRY_BYTES), .CTX_BASE(CTX_BASE)
  ) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .missCtx(missCtx),
    .missVpn(missVpn), .memRspData(memRspData), .rspOk(rspOk),
    .memReqAddr(memReqAddr), .entry(fillPte), .ctxQ(reqCtx), .vpnQ(reqVpn)
  );
endmodule

// File: rtl/walk_chk.sv
module walk_chk #(
  parameter int ADDR_W = 32
)(
  input logic              clk,
  input logic              rst,
  input logic              missReady,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRspValid,
  input logic              fillValid,
  input logic              faultValid
);
  a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqAddr));
  a_r5_single: assert property (@(posedge clk) disable iff (rst)
    memReqValid && memReqReady |=> !memReqValid);
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(fillValid && faultValid));
  a_r8_back_idle: assert property (@(posedge clk) disable iff (rst)
    fillValid || faultValid |=> missReady);
  a_r6_fill_pulse: assert property (@(posedge clk) disable iff (rst)
    fillValid |=> !fillValid);
  a_r7_fault_pulse: assert property (@(posedge clk) disable iff (rst)
    faultValid |=> !faultValid && !memReqValid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    missReady |-> !memReqValid);
  a_r6_after_rsp: assert property (@(posedge clk) disable iff (rst)
    $rose(fillValid) |-> $past(memRspValid));
endmodule

bind tbl_walker walk_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .missReady(missReady), .memReqValid(memReqValid),
  .memReqReady(memReqReady), .memReqAddr(memReqAddr),
  .memRspValid(memRspValid), .fillValid(fillValid), .faultValid(faultValid)
);

// File: tb/tbl_walker_tb.sv
module tbl_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CBASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        missValid = 1'b0;
  logic        missReady;
  logic [7:0]  missCtx = '0;
  logic [19:0] missVpn = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        fillValid;
  logic [31:0] fillPte;
  logic        faultValid;
  logic [1:0]  faultLevel;
  logic [7:0]  reqCtx;
  logic [19:0] reqVpn;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] mem [int unsigned];

  always #(CLK_PERIOD/2) clk = ~clk;

  tbl_walker u_dut (
    .clk(clk), .rst(rst), .missValid(missValid), .missReady(missReady),
    .missCtx(missCtx), .missVpn(missVpn), .memReqValid(memReqValid),
    .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .fillValid(fillValid), .fillPte(fillPte), .faultValid(faultValid),
    .faultLevel(faultLevel), .reqCtx(reqCtx), .reqVpn(reqVpn)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic phase(input bit idle, input bit fill, input bit fault);
    check(missReady == idle, "R2 missReady", 64'(missReady), 64'(idle));
    check(fillValid == fill, "R6 fillValid", 64'(fillValid), 64'(fill));
    check(faultValid == fault, "R7 faultValid", 64'(faultValid), 64'(fault));
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  task automatic model(input logic [7:0] ctx, input logic [19:0] vpn,
                       output logic [31:0] addrs [4], output int nReads,
                       output bit isFault, output int fLvl, output logic [31:0] leaf);
    logic [31:0] e;
    logic [31:0] idx [4];
    idx[1] = 32'(vpn[19:12]);
    idx[2] = 32'(vpn[11:6]);
    idx[3] = 32'(vpn[5:0]);
    addrs[0] = CBASE + 32'(ctx) * 4;
    e = rd(addrs[0]);
    nReads = 1; isFault = 0; fLvl = 0; leaf = 0;
    for (int lv = 1; lv <= 3; lv++) addrs[lv] = 0;
    if (!e[0]) begin isFault = 1; fLvl = 0; return; end
    for (int lv = 1; lv <= 3; lv++) begin
      addrs[lv] = {e[31:2], 2'b00} + idx[lv] * 4;
      e = rd(addrs[lv]);
      nReads++;
      if (!e[0]) begin isFault = 1; fLvl = lv; return; end
    end
    leaf = e;
  endtask

  task automatic walk(input logic [7:0] ctx, input logic [19:0] vpn,
                      input int stall, input int lat, input bit noise);
    logic [31:0] addrs [4];
    int nReads; bit isFault; int fLvl; logic [31:0] leaf;
    model(ctx, vpn, addrs, nReads, isFault, fLvl, leaf);
    phase(1, 0, 0);
    missValid = 1; missCtx = ctx; missVpn = vpn;
    @(negedge clk);
    if (noise) begin missCtx = ctx ^ 8'h5A; missVpn = ~vpn; end
    else missValid = 0;
    for (int r = 0; r < nReads; r++) begin
      for (int s = 0; s < stall; s++) begin
        phase(0, 0, 0);
        check(memReqValid == 1, "R5 request held", 64'(memReqValid), 64'd1);
        check(memReqAddr == addrs[r], "R5 address stable", 64'(memReqAddr), 64'(addrs[r]));
        @(negedge clk);
      end
      phase(0, 0, 0);
      check(memReqValid == 1, "R3 request issued", 64'(memReqValid), 64'd1);
      check(memReqAddr == addrs[r], r == 0 ? "R3 context address" : "R4 level address",
            64'(memReqAddr), 64'(addrs[r]));
      memReqReady = 1;
      @(negedge clk);
      memReqReady = 0;
      for (int l = 0; l < lat; l++) begin
        phase(0, 0, 0);
        check(memReqValid == 0, "R5 single outstanding", 64'(memReqValid), 64'd0);
        @(negedge clk);
      end
      phase(0, 0, 0);
      check(memReqValid == 0, "R5 single outstanding", 64'(memReqValid), 64'd0);
      memRspValid = 1; memRspData = rd(addrs[r]);
      @(negedge clk);
      memRspValid = 0; memRspData = 32'hDEAD_BEEF;
    end
    missValid = 0;
    phase(0, !isFault, isFault);
    check(memReqValid == 0, "R7 no read after end", 64'(memReqValid), 64'd0);
    check(reqCtx == ctx, "R2 context kept", 64'(reqCtx), 64'(ctx));
    check(reqVpn == vpn, "R2 page number kept", 64'(reqVpn), 64'(vpn));
    if (isFault)
      check(faultLevel == 2'(fLvl), "R7 fault level", 64'(faultLevel), 64'(fLvl));
    else
      check(fillPte == leaf, "R6 leaf entry", 64'(fillPte), 64'(leaf));
    @(negedge clk);
    phase(1, 0, 0);
    check(memReqValid == 0, "R8 idle quiet", 64'(memReqValid), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // context 3 -> full path for vpn 0x12345
    mem[CBASE + 3*4] = 32'h0002_0001;
    mem[32'h0002_0000 + 32'h12*4] = 32'h0003_0001;
    mem[32'h0003_0000 + 32'h0D*4] = 32'h0004_0001;
    mem[32'h0004_0000 + 32'h05*4] = 32'hABCD_E03B;
    mem[32'h0004_0000 + 32'h06*4] = 32'h1234_5036;
    // context 9 -> base with low bits set, path to a fill
    mem[CBASE + 9*4] = 32'h0005_0003;
    mem[32'h0005_0000 + 32'hFF*4] = 32'h0006_0007;
    mem[32'h0006_0000 + 32'h3F*4] = 32'h0007_0001;
    mem[32'h0007_0000 + 32'h00*4] = 32'h0000_1009;

    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check(missReady == 1, "R1 ready after reset", 64'(missReady), 64'd1);
    check(memReqValid == 0, "R1 no request", 64'(memReqValid), 64'd0);
    check(fillValid == 0 && faultValid == 0, "R1 no result", 64'({fillValid, faultValid}), 64'd0);

    walk(8'd3, 20'h12345, 0, 0, 0);   // R6 fill, no stalls
    walk(8'd3, 20'h12345, 2, 3, 0);   // R5 stalls and latency
    walk(8'd5, 20'h12345, 1, 0, 0);   // R7 fault at context
    walk(8'd3, 20'h22345, 0, 1, 0);   // R7 fault at level 1
    walk(8'd3, 20'h12385, 0, 0, 0);   // R7 fault at level 2
    walk(8'd3, 20'h12346, 1, 2, 0);   // R7 fault at level 3 (leaf invalid)
    walk(8'd9, 20'hFFFC0, 0, 2, 0);   // R4 low bits of base cleared
    walk(8'd3, 20'h12345, 1, 1, 1);   // R2 miss while busy ignored
    walk(8'd9, 20'hFFFC0, 3, 0, 1);   // R2 again with fill

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule